// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output channel of a general-purpose timer. It sits beside a free-running up-counter, compares the counter value with a stored compare value and, under one of eight modes, drives a reference waveform. The waveform can hold, be set or cleared, toggle, be forced, or carry pulse-width modulation. A compare-match flag is also produced. Software writes the compare value through a one-word write port. With buffering on, the value first lands in a shadow register and reaches the comparator only on an update event, so a PWM period never sees a half-changed threshold.

Two side paths act on the waveform. An external clear level, when enabled, pulls the output inactive at once and holds it there until an update event arrives after the clear level has dropped. A trigger-edge pulse, when the fast path is enabled, acts as a compare match in the current mode without waiting for the counter. The 2-bit channel-selection field must be zero for output operation. Any other value parks the compare logic.

Both outputs are registered. The compare result for the counter value present before clock edge k appears on the outputs just after edge k. The only exception is the external clear, which gates the output combinationally.

Top module: `oc_channel_unit`

## Requirements
- R1: Reset drives the reference output low and the match flag low, and sets the active and shadow compare values to zero. The first cycle after reset with counter 0 therefore gives a match.
- R2: When the channel-selection input is nonzero (1, 2 or 3 mean input use), the reference output keeps its value and the match flag stays low, whatever the mode and the counter.
- R3: Mode 0 (frozen) leaves the reference output unchanged, including on a compare match.
- R4: Mode 1 sets the reference output high on a match, and mode 2 drives it low on a match. Without a match, both modes hold the output.
- R5: Mode 3 inverts the reference output on every clock edge at which the counter equals the active compare value.
- R6: Mode 4 forces the reference output low and mode 5 forces it high, independent of the counter.
- R7: Mode 6 gives a high output when counter < compare and a low output otherwise. Mode 7 gives the inverse. A compare value of 0 keeps mode 6 low and mode 7 high. The unsigned compare is exact at the top count.
- R8: With preload disabled, a write changes the active compare value at the next clock edge.
- R9: With preload enabled, a write only loads the shadow register. The active compare value changes only on a clock edge where the update pulse is high, and it then takes the shadow value.
- R10: With clear enable high, a high external clear level forces the reference output low in the same cycle, without waiting for a clock edge. With clear enable low, the clear input has no effect.
- R11: After the external clear drops, the output stays low until an update pulse is seen. Normal mode behaviour resumes on the clock edge after that update edge.
- R12: With fast enable high, a trigger pulse acts as a compare match for the current mode: modes 1 to 3 as in R4/R5, mode 6 goes low, mode 7 goes high. With fast enable low, the trigger has no effect.
- R13: The match flag is high for exactly the one cycle after each edge at which the counter equalled the active compare value in output mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Counter value |
| wr_en_i | input | 1 | Compare-value write strobe |
| wr_data_i | input | CNT_W | Compare value to write |
| sel_i | input | 2 | Channel selection, 0 = output mode |
| mode_i | input | 3 | Compare mode 0..7 |
| pre_en_i | input | 1 | Preload (shadow) enable |
| fast_en_i | input | 1 | Trigger fast-path enable |
| clr_en_i | input | 1 | External clear enable |
| ext_clr_i | input | 1 | External clear level |
| trig_i | input | 1 | Trigger edge pulse (one cycle) |
| upd_i | input | 1 | Update event pulse |
| oc_ref_o | output | 1 | Reference waveform |
| match_o | output | 1 | Compare-match pulse |

## Verification
The bench targets these corner cases:
- A compare value of zero and of the largest count, where an off-by-one comparator would emit a stray PWM cycle.
- Back-to-back toggles, which a design using a level instead of an edge match would fail to invert twice.
- A preload write with no update, which an unbuffered design would apply at once.
- The clear release: a design that lets go when the clear falls, rather than at the next update, shows a high output too early.
- A disabled fast path, and a nonzero channel selection, where leaking logic would move the output or raise the flag.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [2:0] {
      OCM_FROZEN = 3'd0,
      OCM_SET    = 3'd1,
      OCM_CLR    = 3'd2,
      OCM_TOGGLE = 3'd3,
      OCM_LOW    = 3'd4,
      OCM_HIGH   = 3'd5,
      OCM_PWM_A  = 3'd6,
      OCM_PWM_B  = 3'd7
   } ocm_e;

   localparam logic [1:0] SEL_OUTPUT = 2'd0;
endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
   parameter int CNT_W      = 16,
   parameter bit PRELOAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             pre_en_i,
   input  logic             upd_i,
   output logic [CNT_W-1:0] active_o
);
   logic [CNT_W-1:0] active_q;

   generate
      if (PRELOAD_EN) begin : g_shadow
         logic [CNT_W-1:0] shadow_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow_q <= '0;
               active_q <= '0;
            end else begin
               if (wr_en_i) shadow_q <= wr_data_i;
               if (!pre_en_i && wr_en_i) active_q <= wr_data_i;
               else if (pre_en_i && upd_i) active_q <= shadow_q;
            end
         end

         // R9: buffered writes stay off the comparator until an update
         a_r9_hold_until_update: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en_i && !upd_i) |=> $stable(active_o));
         a_r9_take_shadow: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_en_i && upd_i) |=> (active_o == $past(shadow_q)));
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n)       active_q <= '0;
            else if (wr_en_i) active_q <= wr_data_i;
         end
      end
   endgenerate

   assign active_o = active_q;

   // R8: unbuffered write lands on the next edge
   a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!pre_en_i && wr_en_i) |=> (active_o == $past(wr_data_i)));
endmodule

// File: rtl/oc_clear_gate.sv
module oc_clear_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_en_i,
   input  logic ext_clr_i,
   input  logic upd_i,
   output logic block_o
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          hold_q <= 1'b0;
      else if (!clr_en_i)  hold_q <= 1'b0;
      else if (ext_clr_i)  hold_q <= 1'b1;
      else if (upd_i)      hold_q <= 1'b0;
   end

   assign block_o = clr_en_i & (ext_clr_i | hold_q);

   // R11: once cleared, the block persists while enabled and no update is seen
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && ext_clr_i) |=> (!clr_en_i || block_o));
   a_r11_hold_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (block_o && !upd_i) |=> (!clr_en_i || block_o));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
   import oc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_out_i,
   input  logic [2:0]       mode_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             fast_en_i,
   input  logic             trig_i,
   input  logic             block_i,
   output logic             ref_o,
   output logic             match_o
);
   logic ref_q, ref_nxt, match_q;
   logic eq, lt, fast_hit, hit;
   ocm_e mode;

   assign mode     = ocm_e'(mode_i);
   assign eq       = (cnt_i == cmp_i);
   assign lt       = (cnt_i < cmp_i);
   assign fast_hit = fast_en_i & trig_i;
   assign hit      = eq | fast_hit;

   always_comb begin
      ref_nxt = ref_q;
      unique case (mode)
         OCM_FROZEN: ref_nxt = ref_q;
         OCM_SET:    if (hit) ref_nxt = 1'b1;
         OCM_CLR:    if (hit) ref_nxt = 1'b0;
         OCM_TOGGLE: if (hit) ref_nxt = ~ref_q;
         OCM_LOW:    ref_nxt = 1'b0;
         OCM_HIGH:   ref_nxt = 1'b1;
         OCM_PWM_A:  ref_nxt = fast_hit ? 1'b0 : lt;
         OCM_PWM_B:  ref_nxt = fast_hit ? 1'b1 : ~lt;
         default:    ref_nxt = ref_q;
      endcase
      if (!is_out_i)    ref_nxt = ref_q;
      else if (block_i) ref_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q   <= 1'b0;
         match_q <= 1'b0;
      end else begin
         ref_q   <= ref_nxt;
         match_q <= is_out_i & eq;
      end
   end

   assign ref_o   = ref_q;
   assign match_o = match_q;

   // R2: input-mode channel leaves the waveform alone
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !is_out_i |=> ($stable(ref_q) && !match_q));
   // R3: frozen mode holds
   a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out_i && mode_i == 3'd0 && !block_i) |=> $stable(ref_q));
   // R5: toggle inverts on a counter match
   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out_i && mode_i == 3'd3 && eq && !block_i) |=> (ref_q != $past(ref_q)));
   // R6: forced levels
   a_r6_force_low: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out_i && mode_i == 3'd4) |=> !ref_q);
   a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out_i && mode_i == 3'd5 && !block_i) |=> ref_q);
   // R13: flag follows equality by one edge
   a_r13_match: assert property (@(posedge clk) disable iff (!rst_n)
      (is_out_i && eq) |=> match_q);
   a_r13_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      !eq |=> !match_q);
endmodule

// File: rtl/oc_channel_unit.sv
module oc_channel_unit
   import oc_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit PRELOAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [1:0]       sel_i,
   input  logic [2:0]       mode_i,
   input  logic             pre_en_i,
   input  logic             fast_en_i,
   input  logic             clr_en_i,
   input  logic             ext_clr_i,
   input  logic             trig_i,
   input  logic             upd_i,
   output logic             oc_ref_o,
   output logic             match_o
);
   localparam int MAX_W = 32;

   initial begin
      a_cfg_width: assert (CNT_W >= 2 && CNT_W <= MAX_W)
         else $error("oc_channel_unit: CNT_W=%0d out of range", CNT_W);
   end

   logic [CNT_W-1:0] active_cmp;
   logic             block, ref_raw, is_out;

   assign is_out = (sel_i == SEL_OUTPUT);

   oc_cmp_store #(.CNT_W(CNT_W), .PRELOAD_EN(PRELOAD_EN)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .pre_en_i  (pre_en_i),
      .upd_i     (upd_i),
      .active_o  (active_cmp)
   );

   oc_clear_gate u_clear (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en_i  (clr_en_i),
      .ext_clr_i (ext_clr_i),
      .upd_i     (upd_i),
      .block_o   (block)
   );

   oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_out_i  (is_out),
      .mode_i    (mode_i),
      .cnt_i     (cnt_i),
      .cmp_i     (active_cmp),
      .fast_en_i (fast_en_i),
      .trig_i    (trig_i),
      .block_i   (block),
      .ref_o     (ref_raw),
      .match_o   (match_o)
   );

   assign oc_ref_o = ref_raw & ~block;

   // R10: an enabled clear level pulls the output low in the same cycle
   a_r10_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && ext_clr_i) |-> !oc_ref_o);
endmodule

// File: tb/sim_oc_channel_unit.sv
module sim_oc_channel_unit;
   localparam int W    = 16;
   localparam int NV   = 17;
   localparam logic [W-1:0] IDLE = 16'd12345;

   logic clk = 1'b0;
   logic rst_n;
   logic [W-1:0] cnt_i, wr_data_i;
   logic wr_en_i, pre_en_i, fast_en_i, clr_en_i, ext_clr_i, trig_i, upd_i;
   logic [1:0] sel_i;
   logic [2:0] mode_i;
   logic oc_ref_o, match_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   oc_channel_unit #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .sel_i(sel_i), .mode_i(mode_i),
      .pre_en_i(pre_en_i), .fast_en_i(fast_en_i), .clr_en_i(clr_en_i),
      .ext_clr_i(ext_clr_i), .trig_i(trig_i), .upd_i(upd_i),
      .oc_ref_o(oc_ref_o), .match_o(match_o)
   );

   // row: mode, compare, counter, expected ref, expected match
   localparam logic [36:0] TBL [NV] = '{
      {3'd5, 16'd10,    16'd3,     1'b1, 1'b0},  // R6 force high
      {3'd0, 16'd10,    16'd10,    1'b1, 1'b1},  // R3 frozen on match
      {3'd2, 16'd10,    16'd10,    1'b0, 1'b1},  // R4 clear on match
      {3'd2, 16'd10,    16'd4,     1'b0, 1'b0},  // R4
      {3'd1, 16'd20,    16'd19,    1'b0, 1'b0},  // R4 no match holds
      {3'd1, 16'd20,    16'd20,    1'b1, 1'b1},  // R4 set on match
      {3'd3, 16'd7,     16'd7,     1'b0, 1'b1},  // R5 toggle
      {3'd3, 16'd7,     16'd7,     1'b1, 1'b1},  // R5 toggle again
      {3'd3, 16'd7,     16'd8,     1'b1, 1'b0},  // R5 hold
      {3'd4, 16'd7,     16'd0,     1'b0, 1'b0},  // R6 force low
      {3'd6, 16'd100,   16'd99,    1'b1, 1'b0},  // R7
      {3'd6, 16'd100,   16'd100,   1'b0, 1'b1},  // R7
      {3'd6, 16'd0,     16'd0,     1'b0, 1'b1},  // R7 zero compare
      {3'd7, 16'd100,   16'd99,    1'b0, 1'b0},  // R7
      {3'd7, 16'd100,   16'd100,   1'b1, 1'b1},  // R7
      {3'd7, 16'd0,     16'd5,     1'b1, 1'b0},  // R7 zero compare
      {3'd6, 16'd65535, 16'd65534, 1'b1, 1'b0}   // R7 top count
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cnt_i = '0; wr_data_i = '0; wr_en_i = 1'b0;
      sel_i = 2'd0; mode_i = 3'd0; pre_en_i = 1'b0; fast_en_i = 1'b0;
      clr_en_i = 1'b0; ext_clr_i = 1'b0; trig_i = 1'b0; upd_i = 1'b0;
      repeat (3) step();
      chk("R1 reset ref", oc_ref_o, 1'b0);
      chk("R1 reset match", match_o, 1'b0);
      rst_n = 1'b1;
      step();
      chk("R1 compare zero after reset", match_o, 1'b1);
      chk("R1 ref low after reset", oc_ref_o, 1'b0);

      // table walk, direct writes (R8)
      for (int i = 0; i < NV; i++) begin
         wr_en_i = 1'b1; wr_data_i = TBL[i][33:18]; mode_i = 3'd0; cnt_i = IDLE;
         step();
         wr_en_i = 1'b0; mode_i = TBL[i][36:34]; cnt_i = TBL[i][17:2];
         step();
         chk($sformatf("R8 row %0d ref", i), oc_ref_o, TBL[i][1]);
         chk($sformatf("R13 row %0d match", i), match_o, TBL[i][0]);
      end

      // R9 preload: ref is 1, mode 0 keeps it
      mode_i = 3'd0; pre_en_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'd50; cnt_i = IDLE;
      step();
      wr_en_i = 1'b0; cnt_i = 16'd50;
      step();
      chk("R9 no update keeps old compare", match_o, 1'b0);
      upd_i = 1'b1; cnt_i = IDLE;
      step();
      upd_i = 1'b0; cnt_i = 16'd50;
      step();
      chk("R9 update loads shadow", match_o, 1'b1);
      cnt_i = IDLE;

      // R10 / R11 clear
      mode_i = 3'd5;
      step();
      chk("R6 high before clear", oc_ref_o, 1'b1);
      ext_clr_i = 1'b1;
      step();
      chk("R10 clear ignored when disabled", oc_ref_o, 1'b1);
      clr_en_i = 1'b1;
      #1;
      chk("R10 immediate clear", oc_ref_o, 1'b0);
      step();
      ext_clr_i = 1'b0;
      step();
      step();
      chk("R11 held low after clear drops", oc_ref_o, 1'b0);
      upd_i = 1'b1;
      step();
      upd_i = 1'b0;
      step();
      chk("R11 resumes after update", oc_ref_o, 1'b1);
      clr_en_i = 1'b0;

      // R12 fast trigger
      mode_i = 3'd4;
      step();
      mode_i = 3'd1; trig_i = 1'b1; fast_en_i = 1'b0;
      step();
      chk("R12 trigger ignored without fast", oc_ref_o, 1'b0);
      fast_en_i = 1'b1;
      step();
      chk("R12 trigger sets in mode 1", oc_ref_o, 1'b1);
      trig_i = 1'b0; mode_i = 3'd2;
      step();
      chk("R12 no trigger holds", oc_ref_o, 1'b1);
      trig_i = 1'b1;
      step();
      chk("R12 trigger clears in mode 2", oc_ref_o, 1'b0);
      trig_i = 1'b0; fast_en_i = 1'b0;

      // R2 input selection, active compare is 50
      mode_i = 3'd5; sel_i = 2'd1; cnt_i = 16'd50;
      step();
      chk("R2 ref idle in input mode", oc_ref_o, 1'b0);
      chk("R2 no match in input mode", match_o, 1'b0);
      sel_i = 2'd0;
      step();
      chk("R2 output mode resumes", oc_ref_o, 1'b1);
      chk("R13 match raised", match_o, 1'b1);
      cnt_i = 16'd51;
      step();
      chk("R13 match lasts one cycle", match_o, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule